// File: doc/BRIEF.md
# Dual-Processor Byte Mailbox Port

This block lets two processors swap single bytes through one shared 8-bit port. The master sits on a small synchronous register bus. The slave drives asynchronous active-low chip-select, read and write pins and a bidirectional byte lane. Inside the block the lane is split into separate in, out and output-enable signals.

Traffic toward the slave goes through an outbox register. The master writes the outbox, and the slave reads it by pulling chip-select and read low, which turns the port drivers on. Traffic toward the master goes through an inbox of capture cells. The slave puts a byte on the lane and pulses write. The cells take that byte when the write pulse ends, and the master then reads the inbox over its bus. Each direction has a pending flag. The writer's store sets it and the reader's access clears it. The master sees both flags in a status register.

The slave pins cross into the clock domain through synchronizers. The strobes are decoded on the synchronized copies. The output enable is the only signal decoded straight from the pins, so that read data reaches the lane during the pulse.

Top module: `port_mailbox`

## Requirements
- R1: After reset, outbox and inbox both read 0x00, the status register reads 0x00 and port_oe is low.
- R2: A master write with m_addr=0 stores m_wdata in the outbox. The outbox is readable at address 0 from the next cycle, and status bit 0 (outbox pending) is set.
- R3: port_oe is high exactly while s_cs_n is low, s_rd_n is low and s_wr_n is high. While it is high, port_out equals the outbox.
- R4: When s_rd_n and s_wr_n are low together with s_cs_n low, the access counts as a write: port_oe stays low and the inbox captures the byte.
- R5: When a slave write pulse ends, the inbox takes the port_in value held during the pulse. Status bit 1 (inbox pending) sets SYNC_STAGES+1 clock edges after s_wr_n or s_cs_n rises, and not earlier.
- R6: A master read (m_rd high) with m_addr=1 returns the inbox on m_rdata and clears status bit 1 at that clock edge.
- R7: When a slave read pulse ends, status bit 0 clears SYNC_STAGES+1 clock edges after the pulse ends.
- R8: Slave strobes given while s_cs_n is high have no effect. The inbox and both flags are unchanged and port_oe stays low.
- R9: If a flag is set and cleared in the same cycle, the set wins. This covers a master outbox write at the edge where a slave read completes, and a slave capture at the edge where the master reads the inbox.
- R10: Master writes to address 2 (status) or 3 (reserved) change nothing. Address 3 reads 0x00. Master reads at addresses 0 and 2 clear no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_addr | input | 2 | Master register select: 0 outbox, 1 inbox, 2 status, 3 reserved |
| m_wr | input | 1 | Master write strobe, one cycle per write |
| m_rd | input | 1 | Master read strobe; clears the inbox flag at address 1 |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Master read data, combinational from m_addr |
| s_cs_n | input | 1 | Slave chip select, active low, asynchronous |
| s_rd_n | input | 1 | Slave read, active low, asynchronous |
| s_wr_n | input | 1 | Slave write, active low, asynchronous |
| port_in | input | DATA_W | Byte lane value driven by the slave |
| port_out | output | DATA_W | Byte lane value driven toward the slave (the outbox) |
| port_oe | output | 1 | Drive enable for the byte lane |

## Verification
Master writes and inbox reads update the registers at the clock edge where the strobe is sampled, so the bench checks them at the next falling edge. port_oe and port_out follow the slave pins without a clock, and the bench samples them 1 ns after it drives the pins. A slave write or read takes effect at the SYNC_STAGES+1-th rising edge after the pulse ends. The bench therefore checks at the falling edge after that rising edge, and in one directed case it also checks at the falling edge before it, to confirm the flag has not moved early. The set-versus-clear collisions are timed so the master strobe lands on that same rising edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    REG_OUTBOX = 2'd0,
    REG_INBOX  = 2'd1,
    REG_STATUS = 2'd2,
    REG_RSVD   = 2'd3
  } mbox_reg_e;

  localparam int ST_OUT_PEND = 0;
  localparam int ST_IN_PEND  = 1;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= {WIDTH{RST_VAL}};
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mbox_slave_if.sv
module mbox_slave_if #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_cs_n,
  input  logic s_rd_n,
  input  logic s_wr_n,
  output logic wr_busy,
  output logic wr_done,
  output logic rd_done
);
  logic [2:0] pins_s;
  logic       cs_s, rd_s, wr_s;
  logic       wr_act, rd_act;
  logic       wr_act_q, rd_act_q;

  mbox_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({s_cs_n, s_rd_n, s_wr_n}),
    .q    (pins_s)
  );

  assign {cs_s, rd_s, wr_s} = pins_s;

  // write wins when both strobes are low
  always_comb begin
    wr_act = ~cs_s & ~wr_s;
    rd_act = ~cs_s & ~rd_s & ~wr_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
    end
  end

  assign wr_busy = wr_act;
  assign wr_done = wr_act_q & ~wr_act;
  assign rd_done = rd_act_q & ~rd_act;
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        m_addr,
  input  logic              m_wr,
  input  logic              m_rd,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  input  logic [DATA_W-1:0] port_in,
  input  logic              wr_busy,
  input  logic              wr_done,
  input  logic              rd_done,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] in_q,
  output logic              out_full,
  output logic              in_full
);
  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic [DATA_W-1:0] out_d, in_d;
  logic              out_full_d, in_full_d;
  logic              out_we, in_re;
  logic [DATA_W-1:0] status;

  always_comb begin
    out_we = m_wr & (m_addr == REG_OUTBOX);
    in_re  = m_rd & (m_addr == REG_INBOX);

    shadow_d = wr_busy ? port_in : shadow_q;
    out_d    = out_we  ? m_wdata : out_q;
    in_d     = wr_done ? shadow_q : in_q;

    // a set in the same cycle beats a clear
    out_full_d = out_full;
    if (rd_done) out_full_d = 1'b0;
    if (out_we)  out_full_d = 1'b1;

    in_full_d = in_full;
    if (in_re)   in_full_d = 1'b0;
    if (wr_done) in_full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      out_q    <= '0;
      in_q     <= '0;
      out_full <= 1'b0;
      in_full  <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      out_q    <= out_d;
      in_q     <= in_d;
      out_full <= out_full_d;
      in_full  <= in_full_d;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_OUT_PEND] = out_full;
    status[ST_IN_PEND]  = in_full;
    case (m_addr)
      REG_OUTBOX: m_rdata = out_q;
      REG_INBOX:  m_rdata = in_q;
      REG_STATUS: m_rdata = status;
      default:    m_rdata = '0;
    endcase
  end
endmodule

// File: rtl/port_mailbox.sv
module port_mailbox #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        m_addr,
  input  logic              m_wr,
  input  logic              m_rd,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              s_cs_n,
  input  logic              s_rd_n,
  input  logic              s_wr_n,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out,
  output logic              port_oe
);
  logic              rst_sn;
  logic              wr_busy, wr_done, rd_done;
  logic [DATA_W-1:0] out_q, in_q;
  logic              out_full, in_full;

  mbox_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_sn)
  );

  mbox_slave_if #(.SYNC_STAGES(SYNC_STAGES)) u_slave_if (
    .clk    (clk),
    .rst_n  (rst_sn),
    .s_cs_n (s_cs_n),
    .s_rd_n (s_rd_n),
    .s_wr_n (s_wr_n),
    .wr_busy(wr_busy),
    .wr_done(wr_done),
    .rd_done(rd_done)
  );

  mbox_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .m_addr  (m_addr),
    .m_wr    (m_wr),
    .m_rd    (m_rd),
    .m_wdata (m_wdata),
    .m_rdata (m_rdata),
    .port_in (port_in),
    .wr_busy (wr_busy),
    .wr_done (wr_done),
    .rd_done (rd_done),
    .out_q   (out_q),
    .in_q    (in_q),
    .out_full(out_full),
    .in_full (in_full)
  );

  // drive the lane straight from the pins so data is there during the pulse
  assign port_oe  = ~s_cs_n & ~s_rd_n & s_wr_n;
  assign port_out = out_q;
endmodule

// File: rtl/port_mailbox_chk.sv
module port_mailbox_chk
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [1:0]        m_addr,
  input logic              m_wr,
  input logic              m_rd,
  input logic [DATA_W-1:0] m_wdata,
  input logic              s_cs_n,
  input logic              s_wr_n,
  input logic              port_oe,
  input logic [DATA_W-1:0] out_q,
  input logic [DATA_W-1:0] in_q,
  input logic              out_full,
  input logic              in_full,
  input logic              wr_done
);
  // R2
  outbox_store_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (m_wr && m_addr == REG_OUTBOX) |=> (out_full && out_q == $past(m_wdata)));

  // R4
  write_priority_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!s_cs_n && !s_wr_n) |-> !port_oe);

  // R5
  inbox_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_done |=> $stable(in_q));

  // R6
  inbox_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (m_rd && m_addr == REG_INBOX && !wr_done) |=> !in_full);

  // R9
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_done |=> in_full);

  // R10
  status_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (m_wr && m_addr[1]) |=> $stable(out_q));
endmodule

bind port_mailbox port_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .m_addr  (m_addr),
  .m_wr    (m_wr),
  .m_rd    (m_rd),
  .m_wdata (m_wdata),
  .s_cs_n  (s_cs_n),
  .s_wr_n  (s_wr_n),
  .port_oe (port_oe),
  .out_q   (out_q),
  .in_q    (in_q),
  .out_full(out_full),
  .in_full (in_full),
  .wr_done (wr_done)
);

// File: tb/port_mailbox_bench.sv
`timescale 1ns/1ps
module port_mailbox_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    m_addr;
  logic          m_wr, m_rd;
  logic [DW-1:0] m_wdata, m_rdata;
  logic          s_cs_n, s_rd_n, s_wr_n;
  logic [DW-1:0] port_in, port_out;
  logic          port_oe;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] e_out, e_in;
  logic          e_ofull, e_ifull;

  always #2 clk = ~clk;

  port_mailbox #(.DATA_W(DW), .SYNC_STAGES(2)) u_port_mailbox (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .s_cs_n(s_cs_n), .s_rd_n(s_rd_n),
    .s_wr_n(s_wr_n), .port_in(port_in), .port_out(port_out), .port_oe(port_oe)
  );

  function automatic logic [DW-1:0] exp_status();
    return {6'b0, e_ifull, e_ofull};
  endfunction

  function automatic logic exp_oe(logic cs_n, logic rd_n, logic wr_n);
    return !cs_n && !rd_n && wr_n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    m_addr = 2'd2;
    #1 chk(req, 32'(m_rdata), 32'(exp_status()));
  endtask

  task automatic m_write(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    m_addr = a; m_wdata = d; m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0;
    if (a == 2'd0) begin e_out = d; e_ofull = 1'b1; end
  endtask

  task automatic m_read(logic [1:0] a, string req);
    @(negedge clk);
    m_addr = a; m_rd = 1'b1;
    #1 chk(req, 32'(m_rdata), (a == 2'd0) ? 32'(e_out) : (a == 2'd1) ? 32'(e_in) :
                               (a == 2'd2) ? 32'(exp_status()) : 32'h0);
    @(negedge clk);
    m_rd = 1'b0;
    if (a == 2'd1) e_ifull = 1'b0;
  endtask

  task automatic s_write(logic [DW-1:0] d, logic cs_on, logic both);
    @(negedge clk);
    port_in = d; s_cs_n = !cs_on; s_wr_n = 1'b0; s_rd_n = !both;
    #1 chk(both ? "R4 oe" : "R8 oe", 32'(port_oe), 32'(exp_oe(s_cs_n, s_rd_n, s_wr_n)));
    repeat (2) @(negedge clk);
    s_cs_n = 1'b1; s_wr_n = 1'b1; s_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    if (cs_on) begin e_in = d; e_ifull = 1'b1; end
  endtask

  task automatic s_read(logic cs_on);
    @(negedge clk);
    s_cs_n = !cs_on; s_rd_n = 1'b0;
    #1 chk("R3 oe", 32'(port_oe), 32'(exp_oe(s_cs_n, s_rd_n, s_wr_n)));
    if (cs_on) chk("R3 data", 32'(port_out), 32'(e_out));
    repeat (2) @(negedge clk);
    s_cs_n = 1'b1; s_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    if (cs_on) e_ofull = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; m_addr = '0; m_wr = 1'b0; m_rd = 1'b0; m_wdata = '0;
    s_cs_n = 1'b1; s_rd_n = 1'b1; s_wr_n = 1'b1; port_in = '0;
    e_out = '0; e_in = '0; e_ofull = 1'b0; e_ifull = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    m_addr = 2'd0; #1 chk("R1 outbox", 32'(m_rdata), 32'h0);
    m_addr = 2'd1; #1 chk("R1 inbox", 32'(m_rdata), 32'h0);
    check_status("R1 status");
    chk("R1 oe", 32'(port_oe), 32'h0);

    // R2 outbox write
    m_write(2'd0, 8'hA5);
    m_addr = 2'd0; #1 chk("R2 outbox", 32'(m_rdata), 32'hA5);
    check_status("R2 status");

    // R3 / R7 slave read
    s_read(1'b1);
    check_status("R7 status");

    // R5 timing: not before SYNC_STAGES+1 edges, set at that edge
    @(negedge clk);
    port_in = 8'h3C; s_cs_n = 1'b0; s_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    s_cs_n = 1'b1; s_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    check_status("R5 early");
    @(negedge clk);
    e_in = 8'h3C; e_ifull = 1'b1;
    check_status("R5 status");
    m_read(2'd1, "R6 data");
    check_status("R6 status");

    // R4 both strobes low
    s_write(8'h5A, 1'b1, 1'b1);
    check_status("R4 status");
    m_read(2'd1, "R4 data");

    // R8 strobes without chip select
    s_write(8'hFF, 1'b0, 1'b0);
    check_status("R8 status");
    m_addr = 2'd1; #1 chk("R8 inbox", 32'(m_rdata), 32'(e_in));
    m_write(2'd0, 8'h11);
    s_read(1'b0);
    check_status("R8 read ignored");

    // R10 status/reserved writes, non-clearing reads
    m_write(2'd2, 8'hFF);
    m_write(2'd3, 8'h77);
    m_addr = 2'd0; #1 chk("R10 outbox", 32'(m_rdata), 32'(e_out));
    m_read(2'd3, "R10 rsvd");
    m_read(2'd0, "R10 rd0");
    m_read(2'd2, "R10 rd2");
    check_status("R10 status");

    // R9 outbound: master write lands on the read-completion edge
    @(negedge clk);
    s_cs_n = 1'b0; s_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    s_cs_n = 1'b1; s_rd_n = 1'b1;
    repeat (2) @(negedge clk);
    m_addr = 2'd0; m_wdata = 8'hC3; m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0; e_out = 8'hC3; e_ofull = 1'b1;
    check_status("R9 out set wins");

    // R9 inbound: capture lands on the master read edge
    @(negedge clk);
    port_in = 8'h96; s_cs_n = 1'b0; s_wr_n = 1'b0;
    repeat (2) @(negedge clk);
    s_cs_n = 1'b1; s_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    m_addr = 2'd1; m_rd = 1'b1;
    @(negedge clk);
    m_rd = 1'b0; e_in = 8'h96; e_ifull = 1'b1;
    check_status("R9 in set wins");
    m_addr = 2'd1; #1 chk("R9 in data", 32'(m_rdata), 32'h96);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: m_write(2'($urandom_range(0, 3)), 8'($urandom));
        1: m_read(2'($urandom_range(0, 3)), "R6 rnd read");
        2: s_write(8'($urandom), ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0));
        3: s_read($urandom_range(0, 3) != 0);
        default: check_status("R2 R5 R7 rnd status");
      endcase
    end
    check_status("R10 final status");

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule